// File: doc/BRIEF.md
# Two-Level Lookahead Adder (16 bits)

This block adds two 16-bit operands and a carry-in in a single combinational pass. The word is cut into four slices of four bits. Each slice forms a generate term (both operand bits set) and a propagate term (either operand bit set) for every bit. From these it builds its internal carries as flat sum-of-products expressions, together with a slice-level generate and propagate pair.

A second lookahead stage takes the four slice pairs and the carry-in. It produces the carries into slices 1 to 3 and the final carry-out, again as flat sums of products, so no carry ripples from one slice to the next. Each sum bit is the XOR of the two operand bits and the carry into that position.

The block also drives a whole-word generate and propagate pair, so that a wider adder can place one more lookahead stage above several instances.

Top module: `gcla16_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + cin_i`, taken as unsigned.
- R2: `cout_o` equals bit 16 of the unsigned 17-bit value `a_i + b_i + cin_i`.
- R3: `grp_gen_o` is 1 exactly when `a_i + b_i`, without the carry-in, is at least 65536.
- R4: `grp_prop_o` is 1 exactly when every one of the 16 bit positions has at least one operand bit set, that is, when `a_i | b_i` is 16'hFFFF.
- R5: `cout_o` equals `grp_gen_o | (grp_prop_o & cin_i)` for every input. A parent lookahead stage can therefore use the exported pair in place of the carry-out.
- R6: When the operands complement each other bit for bit (`a_i ^ b_i` = 16'hFFFF and `a_i & b_i` = 0), a carry-in of 1 crosses all four slices: `sum_o` is 0 and `cout_o` is 1. With a carry-in of 0, `sum_o` is 16'hFFFF and `cout_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand, unsigned |
| b_i | input | 16 | Second operand, unsigned |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum, modulo 2^16 |
| cout_o | output | 1 | Carry out of bit 15 |
| grp_gen_o | output | 1 | Whole-word generate (carry-out independent of carry-in) |
| grp_prop_o | output | 1 | Whole-word propagate (carry-in would reach the carry-out) |

## Verification
The checker compares the outputs with the input values that are present at the same moment, and it assumes that every input is a defined 0 or 1. The bench changes inputs only on the rising edge of its clock and reads the outputs on the falling edge, so every comparison sees a settled value. The sweep copies one 8-bit value into both bytes of `a_i` and another into both bytes of `b_i`, and ties the carry-in to their low bits. This puts every combination of generate and propagate into each slice and sends carries across each slice boundary. Directed complementary, all-ones and alternating operands then cover carries that run through every slice.

// File: rtl/gcla_pkg.sv
package gcla_pkg;
   // Default shape of the adder: slice width and slice count.
   parameter int unsigned GCLA_GRP_W  = 4;
   parameter int unsigned GCLA_NGRP   = 4;
   parameter int unsigned GCLA_WIDTH  = GCLA_GRP_W * GCLA_NGRP;
endpackage

// File: rtl/gcla_lookahead.sv
// Flat sum-of-products lookahead over W (generate, propagate) pairs.
// carry_o[i] is the carry into position i (1..W-1). blk_gen_o and blk_prop_o
// summarise the whole span so a higher level can form the span's carry-out.
module gcla_lookahead #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] gen_i,
   input  logic [W-1:0] prop_i,
   input  logic         cin_i,
   output logic [W-1:1] carry_o,
   output logic         blk_gen_o,
   output logic         blk_prop_o
);
   if (W < 2) begin : g_bad_w
      $error("gcla_lookahead: W must be at least 2");
   end

   always_comb begin
      logic acc;
      logic term;
      carry_o = '0;
      for (int i = 1; i < W; i++) begin
         acc = 1'b0;
         for (int j = 0; j < i; j++) begin
            term = gen_i[j];
            for (int k = j + 1; k < i; k++) term = term & prop_i[k];
            acc = acc | term;
         end
         term = cin_i;
         for (int k = 0; k < i; k++) term = term & prop_i[k];
         carry_o[i] = acc | term;
      end
   end

   always_comb begin
      logic acc;
      logic term;
      acc = 1'b0;
      for (int j = 0; j < W; j++) begin
         term = gen_i[j];
         for (int k = j + 1; k < W; k++) term = term & prop_i[k];
         acc = acc | term;
      end
      blk_gen_o = acc;
   end

   assign blk_prop_o = &prop_i;
endmodule

// File: rtl/gcla_group.sv
// One slice: per-bit generate/propagate, local lookahead, sum bits.
module gcla_group #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o,
   output logic         gg_o,
   output logic         gp_o
);
   logic [W-1:0] bit_gen;
   logic [W-1:0] bit_prop;
   logic [W-1:1] inner_c;
   logic [W-1:0] c_at;

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign bit_gen[i]  = a_i[i] & b_i[i];
      assign bit_prop[i] = a_i[i] | b_i[i];
   end

   gcla_lookahead #(.W(W)) u_la (
      .gen_i      (bit_gen),
      .prop_i     (bit_prop),
      .cin_i      (cin_i),
      .carry_o    (inner_c),
      .blk_gen_o  (gg_o),
      .blk_prop_o (gp_o)
   );

   assign c_at = {inner_c, cin_i};

   for (genvar i = 0; i < W; i++) begin : g_sum
      assign sum_o[i] = a_i[i] ^ b_i[i] ^ c_at[i];
   end
endmodule

// File: rtl/gcla16_adder.sv
// Two-level group carry-lookahead adder: NGRP slices of GRP_W bits, with a
// second lookahead stage that forms every slice carry-in directly.
module gcla16_adder #(
   parameter int unsigned GRP_W = gcla_pkg::GCLA_GRP_W,
   parameter int unsigned NGRP  = gcla_pkg::GCLA_NGRP,
   localparam int unsigned WIDTH = GRP_W * NGRP
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o,
   output logic             grp_gen_o,
   output logic             grp_prop_o
);
   if (GRP_W < 2 || NGRP < 2) begin : g_bad_shape
      $error("gcla16_adder: GRP_W and NGRP must each be at least 2");
   end
   if (WIDTH != 16) begin : g_bad_width
      $error("gcla16_adder: the adder is defined for 16 bits only");
   end

   logic [NGRP-1:0] slice_gg;
   logic [NGRP-1:0] slice_gp;
   logic [NGRP-1:1] slice_cin;
   logic [NGRP-1:0] c_into;

   gcla_lookahead #(.W(NGRP)) u_level2 (
      .gen_i      (slice_gg),
      .prop_i     (slice_gp),
      .cin_i      (cin_i),
      .carry_o    (slice_cin),
      .blk_gen_o  (grp_gen_o),
      .blk_prop_o (grp_prop_o)
   );

   assign c_into = {slice_cin, cin_i};

   for (genvar g = 0; g < NGRP; g++) begin : g_slice
      gcla_group #(.W(GRP_W)) u_grp (
         .a_i   (a_i[g*GRP_W +: GRP_W]),
         .b_i   (b_i[g*GRP_W +: GRP_W]),
         .cin_i (c_into[g]),
         .sum_o (sum_o[g*GRP_W +: GRP_W]),
         .gg_o  (slice_gg[g]),
         .gp_o  (slice_gp[g])
      );
   end

   // Final carry, flat: whole-word generate plus whole-word propagate with c0.
   assign cout_o = grp_gen_o | (grp_prop_o & cin_i);
endmodule

// File: rtl/gcla16_adder_chk.sv
// Checker bound to the adder; relates ports through arithmetic of its own.
module gcla16_adder_chk #(
   parameter int unsigned WIDTH = 16
) (
   input logic [WIDTH-1:0] a_i,
   input logic [WIDTH-1:0] b_i,
   input logic             cin_i,
   input logic [WIDTH-1:0] sum_o,
   input logic             cout_o,
   input logic             grp_gen_o,
   input logic             grp_prop_o
);
   logic [WIDTH:0] full_sum;
   logic [WIDTH:0] no_cin_sum;

   assign full_sum   = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
   assign no_cin_sum = {1'b0, a_i} + {1'b0, b_i};

   always_comb begin
      a_r1_sum_value: assert (sum_o == full_sum[WIDTH-1:0])
         else $error("R1 sum mismatch");
      a_r2_carry_out: assert (cout_o == full_sum[WIDTH])
         else $error("R2 carry-out mismatch");
      a_r3_word_generate: assert (grp_gen_o == no_cin_sum[WIDTH])
         else $error("R3 word generate mismatch");
      a_r4_word_propagate: assert (grp_prop_o == (&(a_i | b_i)))
         else $error("R4 word propagate mismatch");
      a_r5_gen_forces_cout: assert (!grp_gen_o || cout_o)
         else $error("R5 generate without carry-out");
      a_r6_full_chain: assert (!((&(a_i ^ b_i)) && cin_i) || (sum_o == '0 && cout_o))
         else $error("R6 carry did not cross all slices");
   end
endmodule

bind gcla16_adder gcla16_adder_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_gcla16_adder.sv
`timescale 1ns/1ps
module tb_gcla16_adder;
   logic        clk = 1'b0;
   logic [15:0] a_i = '0;
   logic [15:0] b_i = '0;
   logic        cin_i = 1'b0;
   logic [15:0] sum_o;
   logic        cout_o;
   logic        grp_gen_o;
   logic        grp_prop_o;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   gcla16_adder dut (
      .a_i        (a_i),
      .b_i        (b_i),
      .cin_i      (cin_i),
      .sum_o      (sum_o),
      .cout_o     (cout_o),
      .grp_gen_o  (grp_gen_o),
      .grp_prop_o (grp_prop_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s a=%h b=%h cin=%0d actual=%h expected=%h", req, a_i, b_i, cin_i, act, exp);
      end
   endtask

   task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic c);
      logic [16:0] e_full;
      logic [16:0] e_nocin;
      @(posedge clk);
      a_i = a; b_i = b; cin_i = c;
      @(negedge clk);
      e_full  = {1'b0, a} + {1'b0, b} + {16'd0, c};
      e_nocin = {1'b0, a} + {1'b0, b};
      chk("R1", {16'd0, sum_o}, {16'd0, e_full[15:0]});
      chk("R2", {31'd0, cout_o}, {31'd0, e_full[16]});
      chk("R3", {31'd0, grp_gen_o}, {31'd0, e_nocin[16]});
      chk("R4", {31'd0, grp_prop_o}, {31'd0, (&(a | b))});
      chk("R5", {31'd0, cout_o}, {31'd0, grp_gen_o | (grp_prop_o & c)});
   endtask

   initial begin
      // Initial state with all inputs zero.
      @(negedge clk);
      chk("R1", {16'd0, sum_o}, 32'd0);
      chk("R2", {31'd0, cout_o}, 32'd0);

      // R6: complementary operands carry the carry-in through every slice.
      apply(16'hFFFF, 16'h0000, 1'b1);
      chk("R6", {15'd0, cout_o, sum_o}, {15'd0, 1'b1, 16'h0000});
      apply(16'hAAAA, 16'h5555, 1'b1);
      chk("R6", {15'd0, cout_o, sum_o}, {15'd0, 1'b1, 16'h0000});
      apply(16'h0F0F, 16'hF0F0, 1'b0);
      chk("R6", {15'd0, cout_o, sum_o}, {15'd0, 1'b0, 16'hFFFF});

      // Corner operands.
      apply(16'hFFFF, 16'hFFFF, 1'b1);
      apply(16'hFFFF, 16'hFFFF, 1'b0);
      apply(16'h8000, 16'h8000, 1'b0);
      apply(16'h000F, 16'h0001, 1'b0);
      apply(16'h0FFF, 16'h0001, 1'b0);
      apply(16'hAAAA, 16'hAAAA, 1'b1);
      apply(16'h5555, 16'h5555, 1'b0);

      // Near-exhaustive sweep: byte patterns replicated into both bytes.
      for (int x = 0; x < 256; x++) begin
         for (int y = 0; y < 256; y++) begin
            apply({x[7:0], x[7:0]}, {y[7:0], y[7:0]}, x[0] ^ y[0]);
         end
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule